// File: doc/BRIEF.md
# Ring and Indirect Buffer Command Fetcher

This block feeds a command-packet decoder with 32-bit command words. The words come from two kinds of source. The first is a primary circular ring in memory: software sets its base and size and moves a write pointer, and the block moves its own read pointer behind it. The second is a set of linear indirect buffers. The decoder places one of these on an internal stack when it decodes an indirect-buffer packet. Fetching always takes words from the buffer at the top of the stack. An indirect buffer that has run out is popped, and fetching then continues in the buffer below it. The primary ring always sits at the bottom of the stack.

The memory read port has a fixed latency of one cycle. Fetched words reach the decoder through a valid/ready output. When writeback is enabled, the block also reports each new primary read pointer on a memory write port. Packet decoding and address translation are handled outside this block.

Top module: `ringIbFetcher`

## Requirements
- R1: While reset is held and in the first cycle after it, `outValid`, `memRdEn`, `wbValid` and `ibOverflow` are low. The primary read pointer starts at 0.
- R2: The primary ring holds 2^(`ringSizeLog2`+3) dwords. Each primary read uses the address `ringBase` + read pointer. The read pointer then increments modulo the ring size, so after the last slot it continues at slot 0.
- R3: The block reads from the primary ring only while the read pointer differs from `hostWptr` masked to the ring size. Bits of `hostWptr` above the ring size are ignored. When the two pointers are equal, no word is produced.
- R4: A pushed indirect buffer produces the dwords at `ibPushBase` + 0 up to `ibPushBase` + `ibPushLen` − 1, in rising address order with no wraparound. The buffer is then popped.
- R5: While an indirect buffer is on the stack, it takes precedence over the primary ring, and `hostWptr` has no effect on it. Primary data that became pending in the meantime is fetched after the last pop.
- R6: The most recently pushed buffer is served first. After it pops, the buffer below continues from the offset it had reached.
- R7: An indirect buffer of length 0 is popped without producing any word.
- R8: The stack holds up to 4 indirect buffers. A push while 4 are held is dropped, and `ibOverflow` is high for the one cycle after that push.
- R9: While `wbEnable` is high, every primary read is followed in the next cycle by a one-cycle `wbValid`, with `wbRptr` equal to the new read pointer and `wbAddrOut` equal to `wbAddr`. Indirect-buffer reads, and primary reads with `wbEnable` low, produce no writeback.
- R10: While `outValid` is high and `outReady` is low, `outValid` and `outData` hold their values. A push takes effect in the cycle it is presented, and the dword already fetched is delivered before any word from the new buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringBase | input | 32 | Primary ring base dword address |
| ringSizeLog2 | input | 4 | Ring size code; ring has 2^(code+3) dwords |
| hostWptr | input | 16 | Host-written primary write pointer |
| wbEnable | input | 1 | Enables read-pointer writeback |
| wbAddr | input | 32 | Writeback destination address |
| ibPushValid | input | 1 | Push an indirect buffer this cycle |
| ibPushBase | input | 32 | Indirect buffer base dword address |
| ibPushLen | input | 16 | Indirect buffer length in dwords |
| memRdEn | output | 1 | Memory read request |
| memRdAddr | output | 32 | Memory read dword address |
| memRdData | input | 32 | Read data, valid one cycle after request |
| outValid | output | 1 | Command dword available |
| outReady | input | 1 | Decoder accepts the dword |
| outData | output | 32 | Command dword |
| ibOverflow | output | 1 | One-cycle pulse: push dropped, stack full |
| wbValid | output | 1 | Writeback strobe |
| wbAddrOut | output | 32 | Writeback address |
| wbRptr | output | 16 | Read pointer value to write back |

## Verification
The hardest case to reach is the moment a buffer runs out while the source underneath has work of its own. This covers an indirect buffer that finishes while the primary ring has pending data, and an inner buffer that pops back into an outer buffer it interrupted part-way. The stimulus creates the first case by presenting a push and a write-pointer advance in the same idle cycle. It creates the second by holding `outReady` low, so the outer buffer's first dword stays parked at the output while the inner push arrives. A full stack is reached by four back-to-back pushes, which starve the fetch step, followed by a fifth. Random ready throttling and random pointer advances across a ring boundary cover the ordinary flow.

// File: rtl/ringFetchPkg.sv
package ringFetchPkg;
  // Control-to-datapath strobes for one cycle.
  typedef struct packed {
    logic push;      // load new indirect level
    logic pop;       // drop exhausted top level
    logic readIb;    // read from top indirect level
    logic readPrim;  // read from primary ring
    logic capture;   // latch returned memory word
  } fetchStrobe_t;

  // Datapath-to-control status.
  typedef struct packed {
    logic ibActive;     // at least one indirect level stacked
    logic ibDone;       // top indirect level fully read
    logic primPending;  // primary read pointer behind write pointer
    logic full;         // no free indirect level
  } fetchStatus_t;
endpackage

// File: rtl/ringFetchCtrl.sv
module ringFetchCtrl
  import ringFetchPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  fetchStatus_t st,
  input  logic         ibPushValid,
  input  logic         outReady,
  output fetchStrobe_t stb,
  output logic         outValid,
  output logic         ibOverflow
);
  typedef enum logic [1:0] {S_FETCH, S_WAIT, S_HOLD} fetchState_t;

  fetchState_t state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    stb.push  = ibPushValid && !st.full;
    unique case (state)
      S_FETCH: begin
        // A push cycle skips the fetch step so the stack changes once.
        if (!ibPushValid) begin
          if (st.ibActive) begin
            if (st.ibDone) begin
              stb.pop = 1'b1;
            end else begin
              stb.readIb = 1'b1;
              stateNext  = S_WAIT;
            end
          end else if (st.primPending) begin
            stb.readPrim = 1'b1;
            stateNext    = S_WAIT;
          end
        end
      end
      S_WAIT: begin
        stb.capture = 1'b1;
        stateNext   = S_HOLD;
      end
      S_HOLD: begin
        if (outReady) stateNext = S_FETCH;
      end
      default: stateNext = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_FETCH;
      ibOverflow <= 1'b0;
    end else begin
      state      <= stateNext;
      ibOverflow <= ibPushValid && st.full;
    end
  end

  assign outValid = (state == S_HOLD);
endmodule

// File: rtl/ringFetchPath.sv
module ringFetchPath
  import ringFetchPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int PTR_W       = 16,
  parameter int LEN_W       = 16,
  parameter int SZ_W        = 4,
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrobe_t      stb,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [SZ_W-1:0]   ringSizeLog2,
  input  logic [PTR_W-1:0]  hostWptr,
  input  logic              wbEnable,
  input  logic [ADDR_W-1:0] wbAddr,
  input  logic [ADDR_W-1:0] ibPushBase,
  input  logic [LEN_W-1:0]  ibPushLen,
  input  logic [DATA_W-1:0] memRdData,
  output fetchStatus_t      st,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [DATA_W-1:0] outData,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddrOut,
  output logic [PTR_W-1:0]  wbRptr
);
  localparam int LVL_W = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  logic [LVL_W-1:0]  depth;
  logic [IDX_W-1:0]  topIdx;
  logic [ADDR_W-1:0] lvlBase [STACK_DEPTH];
  logic [LEN_W-1:0]  lvlOff  [STACK_DEPTH];
  logic [LEN_W-1:0]  lvlLen  [STACK_DEPTH];

  logic [PTR_W-1:0]  rptr, rptrNext, ringMask, wptrMasked;
  logic [SZ_W:0]     shAmt;

  // Ring length in dwords is 2^(code+3); mask is that minus one.
  assign shAmt      = {1'b0, ringSizeLog2} + (SZ_W+1)'(3);
  assign ringMask   = (PTR_W'(1) << shAmt) - PTR_W'(1);
  assign wptrMasked = hostWptr & ringMask;
  assign rptrNext   = (rptr + PTR_W'(1)) & ringMask;
  assign topIdx     = IDX_W'(depth - LVL_W'(1));

  // One register set per stack level.
  for (genvar g = 0; g < STACK_DEPTH; g++) begin : gLevel
    logic [ADDR_W-1:0] baseQ;
    logic [LEN_W-1:0]  offQ, lenQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ <= '0;
        offQ  <= '0;
        lenQ  <= '0;
      end else if (stb.push && depth == LVL_W'(g)) begin
        baseQ <= ibPushBase;
        offQ  <= '0;
        lenQ  <= ibPushLen;
      end else if (stb.readIb && topIdx == IDX_W'(g)) begin
        offQ  <= offQ + LEN_W'(1);
      end
    end
    assign lvlBase[g] = baseQ;
    assign lvlOff[g]  = offQ;
    assign lvlLen[g]  = lenQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth     <= '0;
      rptr      <= '0;
      outData   <= '0;
      wbValid   <= 1'b0;
      wbAddrOut <= '0;
      wbRptr    <= '0;
    end else begin
      if (stb.push)         depth <= depth + LVL_W'(1);
      else if (stb.pop)     depth <= depth - LVL_W'(1);
      if (stb.readPrim)     rptr <= rptrNext;
      if (stb.capture)      outData <= memRdData;
      wbValid <= stb.readPrim && wbEnable;
      if (stb.readPrim) begin
        wbRptr    <= rptrNext;
        wbAddrOut <= wbAddr;
      end
    end
  end

  assign st.ibActive    = (depth != '0);
  assign st.ibDone      = (lvlOff[topIdx] == lvlLen[topIdx]);
  assign st.primPending = (rptr != wptrMasked);
  assign st.full        = (depth == LVL_W'(STACK_DEPTH));

  assign memRdEn   = stb.readIb || stb.readPrim;
  assign memRdAddr = stb.readIb ? lvlBase[topIdx] + ADDR_W'(lvlOff[topIdx])
                                : ringBase + ADDR_W'(rptr);
endmodule

// File: rtl/ringIbFetcher.sv
module ringIbFetcher
  import ringFetchPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int PTR_W       = 16,
  parameter int LEN_W       = 16,
  parameter int SZ_W        = 4,
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [SZ_W-1:0]   ringSizeLog2,
  input  logic [PTR_W-1:0]  hostWptr,
  input  logic              wbEnable,
  input  logic [ADDR_W-1:0] wbAddr,
  input  logic              ibPushValid,
  input  logic [ADDR_W-1:0] ibPushBase,
  input  logic [LEN_W-1:0]  ibPushLen,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              ibOverflow,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddrOut,
  output logic [PTR_W-1:0]  wbRptr
);
  fetchStrobe_t stb;
  fetchStatus_t st;

  ringFetchCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .ibPushValid(ibPushValid),
    .outReady   (outReady),
    .stb        (stb),
    .outValid   (outValid),
    .ibOverflow (ibOverflow)
  );

  ringFetchPath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W),
    .LEN_W(LEN_W), .SZ_W(SZ_W), .STACK_DEPTH(STACK_DEPTH)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .ringBase    (ringBase),
    .ringSizeLog2(ringSizeLog2),
    .hostWptr    (hostWptr),
    .wbEnable    (wbEnable),
    .wbAddr      (wbAddr),
    .ibPushBase  (ibPushBase),
    .ibPushLen   (ibPushLen),
    .memRdData   (memRdData),
    .st          (st),
    .memRdEn     (memRdEn),
    .memRdAddr   (memRdAddr),
    .outData     (outData),
    .wbValid     (wbValid),
    .wbAddrOut   (wbAddrOut),
    .wbRptr      (wbRptr)
  );
endmodule

// File: rtl/ringIbFetcher_chk.sv
module ringIbFetcher_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              memRdEn,
  input logic              ibPushValid,
  input logic              ibOverflow,
  input logic              wbValid,
  input logic              wbEnable
);
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  p_no_read_while_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !memRdEn);

  p_single_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  p_read_reaches_out_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> ##1 outValid);

  p_overflow_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    ibOverflow |-> $past(ibPushValid));

  p_wb_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> $past(wbEnable) && $past(memRdEn));
endmodule

bind ringIbFetcher ringIbFetcher_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/ringIbFetcher_bench.sv
module ringIbFetcher_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] ringBase;
  logic [3:0]  ringSizeLog2;
  logic [15:0] hostWptr;
  logic        wbEnable;
  logic [31:0] wbAddr;
  logic        ibPushValid;
  logic [31:0] ibPushBase;
  logic [15:0] ibPushLen;
  logic        memRdEn;
  logic [31:0] memRdAddr;
  logic [31:0] memRdData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] outData;
  logic        ibOverflow;
  logic        wbValid;
  logic [31:0] wbAddrOut;
  logic [15:0] wbRptr;

  int checkCount = 0;
  int failCount  = 0;
  int readyMode  = 1;   // 0 random, 1 low, 2 high
  int wbCount    = 0;
  logic [15:0] lastWb = '0;
  bit   done = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  bit          prevHold = 1'b0;
  logic [31:0] prevData = '0;

  always #5 clk = ~clk;

  ringIbFetcher u_ringIbFetcher (.*);

  function automatic logic [31:0] memWord(logic [31:0] a);
    return a ^ 32'hA5C3_0000;
  endfunction

  // Memory model: one-cycle read latency.
  always @(posedge clk) if (memRdEn) memRdData <= memWord(memRdAddr);

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic expect1(logic [31:0] addr, string req);
    expQ.push_back(memWord(addr));
    tagQ.push_back(req);
  endtask

  // Decoder model and writeback monitor, sampled on falling edges.
  always @(negedge clk) begin
    if (rstN) begin
      if (readyMode == 0) outReady = ($urandom % 4) != 0;
      else                outReady = (readyMode == 2);
      if (prevHold) check(outValid && outData == prevData, "R10", "held word changed", outData, prevData);
      prevHold = outValid && !outReady;
      prevData = outData;
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3", "unexpected word", outData, 32'h0);
        end else begin
          check(outData == expQ[0], tagQ[0], "stream word", outData, expQ[0]);
          void'(expQ.pop_front());
          void'(tagQ.pop_front());
        end
      end
      if (wbValid) begin
        wbCount++;
        lastWb = wbRptr;
        check(wbAddrOut == wbAddr, "R9", "writeback address", wbAddrOut, wbAddr);
      end
    end
  end

  task automatic doPush(logic [31:0] base, logic [15:0] len);
    ibPushValid = 1'b1;
    ibPushBase  = base;
    ibPushLen   = len;
    @(negedge clk);
    ibPushValid = 1'b0;
  endtask

  task automatic drain(string req);
    int n = 0;
    while (expQ.size() != 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(expQ.size() == 0, req, "stream drained", expQ.size(), 0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCount++;
      failCount++;
      $display("FAIL all watchdog expired: actual 0x%08h expected 0x%08h", 0, 1);
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    int ptr;
    void'($urandom(32'd4242));
    rstN = 1'b0; ringBase = 32'h100; ringSizeLog2 = 4'd0; hostWptr = '0;
    wbEnable = 1'b1; wbAddr = 32'h8000; ibPushValid = 1'b0;
    ibPushBase = '0; ibPushLen = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!outValid && !memRdEn && !wbValid && !ibOverflow, "R1", "outputs in reset",
          {outValid, memRdEn, wbValid, ibOverflow}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !memRdEn && !wbValid && !ibOverflow, "R1", "outputs after reset",
          {outValid, memRdEn, wbValid, ibOverflow}, 0);
    readyMode = 0;
    // R3: equal pointers, nothing produced
    drain("R3");

    // R2/R3: upper write-pointer bits ignored, then wrap through slot 0
    for (int i = 0; i < 5; i++) expect1(32'h100 + i, "R3");
    hostWptr = 16'h0805;
    drain("R3");
    for (int i = 5; i < 10; i++) expect1(32'h100 + (i % 8), "R2");
    hostWptr = 16'd2;
    drain("R2");
    check(wbCount == 10, "R9", "writeback count", wbCount, 10);
    check(lastWb == 16'd2, "R9", "writeback pointer after wrap", lastWb, 2);

    // R4/R5: push and write-pointer advance in the same cycle
    for (int i = 0; i < 3; i++) expect1(32'h2000 + i, "R5");
    expect1(32'h102, "R5");
    expect1(32'h103, "R5");
    hostWptr = 16'd4;
    doPush(32'h2000, 16'd3);
    drain("R4");
    check(wbCount == 12, "R9", "no writeback for indirect reads", wbCount, 12);
    check(lastWb == 16'd4, "R9", "writeback pointer", lastWb, 4);

    // R6: inner push while outer's first word is parked at the output
    readyMode = 1;
    doPush(32'h3000, 16'd2);
    for (int n = 0; n < 50 && !outValid; n++) @(negedge clk);
    check(outValid && outData == memWord(32'h3000), "R6", "outer first word parked",
          outData, memWord(32'h3000));
    doPush(32'h4000, 16'd2);
    expect1(32'h3000, "R6"); expect1(32'h4000, "R6");
    expect1(32'h4001, "R6"); expect1(32'h3001, "R6");
    readyMode = 0;
    drain("R6");

    // R7: zero-length buffer is popped with no output
    doPush(32'h7000, 16'd0);
    repeat (6) @(negedge clk);
    expect1(32'h104, "R7");
    hostWptr = 16'd5;
    drain("R7");

    // R8: four back-to-back pushes fill the stack, fifth is dropped
    readyMode = 1;
    doPush(32'h5000, 16'd1);
    doPush(32'h5100, 16'd1);
    doPush(32'h5200, 16'd1);
    doPush(32'h5300, 16'd1);
    check(!ibOverflow, "R8", "no overflow at fourth push", ibOverflow, 0);
    doPush(32'h6000, 16'd1);
    check(ibOverflow, "R8", "overflow after fifth push", ibOverflow, 1);
    @(negedge clk);
    check(!ibOverflow, "R8", "overflow is one cycle", ibOverflow, 0);
    expect1(32'h5300, "R8"); expect1(32'h5200, "R8");
    expect1(32'h5100, "R8"); expect1(32'h5000, "R8");
    readyMode = 0;
    drain("R8");

    // R2/R9: random pointer advances on a 16-dword ring, writeback off
    wbEnable = 1'b0;
    ringSizeLog2 = 4'd1;
    ringBase = 32'h400;
    ptr = 5;
    for (int it = 0; it < 600; it++) begin
      int adv;
      @(negedge clk);
      adv = ($urandom % 3 == 0) ? 1 + int'($urandom % 3) : 0;
      if (adv != 0 && expQ.size() + adv < 15) begin
        for (int k = 0; k < adv; k++) begin
          expect1(32'h400 + 32'(ptr), "R2");
          ptr = (ptr + 1) % 16;
        end
        hostWptr = 16'(ptr);
      end
    end
    drain("R2");
    check(wbCount == 13, "R9", "no writeback while disabled", wbCount, 13);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule